// File: doc/BRIEF.md
# Serial Memory Command Interface

This block is the slave side of a three-wire serial memory port. It holds 256 words of 16 bits in on-chip registers. A host frames each instruction with chip select (`cs`) and clocks bits on `di` with the serial clock `sk`. The block decodes a start bit, a two-bit opcode and an eight-bit address. It then streams read data back on `do_o`, accepts write data, or acts on a protection boundary register. Two level inputs steer the decode. `pe` permits programming, and `pre` routes an instruction to the protection register instead of the array.

All serial inputs are sampled in the `clk` domain and are assumed to be synchronous to it already. A rising edge of `sk` is the cycle in which `sk` is high and was low one clock earlier. Programming does not start on an `sk` edge. It starts when `cs` falls after a complete write-type frame. It then occupies the block for a fixed number of `clk` cycles, set by `PROG_CYCLES`. A separate protection controller holds the write-enable latch, the boundary register, the arming step and the permanent lock. It grants or denies each decoded instruction.

`do_oe` is the output enable for the serial data pin. The pad that tri-states it sits outside this block.

Top module: `mw_serial_mem`

## Requirements
- R1: Each frame starts with a 1 on `di` at an `sk` rising edge while `cs` is high. Zeros before that bit are ignored. Two opcode bits and eight address bits follow, each sent MSB first.
- R2: A read (`pre`=0, opcode 10) has two phases. On the `sk` rise that takes the last address bit, `do_o` is driven to a 0 dummy bit with `do_oe`=1. The following 16 rises then present the addressed word, D15 first.
- R3: If `cs` stays high after a read, the next word (address + 1, with 255 wrapping to 0) follows straight after D0. No dummy bit comes between words.
- R4: After reset, word writes and write-all are refused. A write-enable (`pre`=0, opcode 00, address 11xxxxxx, `pe`=1) permits them, and a write-disable (opcode 00, address 00xxxxxx) refuses them again. A write-type instruction is only accepted when `pe` is 1 on the `sk` rise that takes its last address bit. After that rise, `pe` has no effect.
- R5: A word write (`pre`=0, opcode 01) takes 16 data bits, MSB first. It commits on the falling edge of `cs`. An extra `sk` rise before `cs` falls cancels the write.
- R6: Once programming starts, the block is busy for `PROG_CYCLES` clocks, and any frame sent in that time is ignored. While `cs` is high in that time, `do_oe`=1 and `do_o`=0. After the busy time ends, `do_o`=1 until the next start bit.
- R7: A write-all (`pre`=0, opcode 00, address 01xxxxxx) writes the 16 data bits to every word. It is refused whenever a protection boundary is set.
- R8: `do_oe` is 0 whenever `cs` is low, and 0 during frames that return no data.
- R9: With `pre`=0, every instruction acts on the array. With `pre`=1, opcode 10 returns a 0 dummy bit followed by the 8-bit boundary value, which reads 0xFF when no boundary is set, and then zeros.
- R10: The arming instruction (`pre`=1, `pe`=1, opcode 00, address 11xxxxxx) needs the write-enable state. Set-boundary, clear-boundary and lock are only accepted as the very next instruction after it. Any other instruction in between cancels the arming.
- R11: Set-boundary (`pre`=1, opcode 01, address A) is only accepted while no boundary is set. Once it commits, word writes to addresses >= A are refused.
- R12: Clear-boundary (`pre`=1, opcode 11, address 0xFF) removes the boundary, so every word can be written.
- R13: Lock (`pre`=1, opcode 00, address 00000000) freezes the boundary for good. Later set-boundary and clear-boundary instructions are ignored.
- R14: Driving `cs` low discards any partial frame. The next frame decodes from its own start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, frames one instruction |
| sk | input | 1 | Serial clock; bits move on its rising edge |
| di | input | 1 | Serial data in |
| pe | input | 1 | Programming permit level |
| pre | input | 1 | Routes the instruction to the protection register |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe | output | 1 | Output enable for the data-out pad |

## Verification
The checker watches several relations on every clock. `do_oe` stays off with `cs` low. Programming only starts on a `cs` fall and is followed by busy. No frame leaves idle while the block is busy. Every decoded read opens with the dummy zero. Array writes only commit with the enable latch set and below the boundary. Write-all only commits with no boundary. A lock freezes the boundary.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model of memory and protection state. These cover the bit order and word contents of single, streaming and wrapping reads, and cancelling a write with an extra clock. They also cover frames sent during the busy time, the arming chain being broken by an unrelated instruction, and resynchronisation after `cs` drops part way through a frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_AW    = 8;
  localparam int MW_DW    = 16;
  localparam int MW_WORDS = 1 << MW_AW;
  localparam int MW_HDR   = 2 + MW_AW;   // opcode + address bits after the start bit

  typedef enum logic [3:0] {
    I_NONE, I_READ, I_WRITE, I_WRALL, I_WEN, I_WDS,
    I_PRREAD, I_PREN, I_PRCLR, I_PRWR, I_PRDS
  } mw_ins_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_DATA, ST_WAIT, ST_DEAD
  } mw_st_e;

  function automatic mw_ins_e mw_decode(input logic [1:0] op,
                                        input logic [MW_AW-1:0] a,
                                        input logic pre);
    mw_ins_e r;
    r = I_NONE;
    if (!pre) begin
      case (op)
        2'b10: r = I_READ;
        2'b01: r = I_WRITE;
        2'b00: begin
          case (a[MW_AW-1 -: 2])
            2'b11:   r = I_WEN;
            2'b00:   r = I_WDS;
            2'b01:   r = I_WRALL;
            default: r = I_NONE;
          endcase
        end
        default: r = I_NONE;
      endcase
    end else begin
      case (op)
        2'b10: r = I_PRREAD;
        2'b01: r = I_PRWR;
        2'b11: r = (&a) ? I_PRCLR : I_NONE;
        default: begin
          if (a[MW_AW-1 -: 2] == 2'b11) r = I_PREN;
          else if (a == '0)             r = I_PRDS;
          else                          r = I_NONE;
        end
      endcase
    end
    return r;
  endfunction

  function automatic logic mw_below(input logic [MW_AW-1:0] a,
                                    input logic [MW_AW-1:0] lim);
    return a < lim;
  endfunction

  function automatic logic [MW_AW-1:0] mw_next(input logic [MW_AW-1:0] a);
    return a + MW_AW'(1);
  endfunction
endpackage

// File: rtl/mw_protect.sv
module mw_protect
  import mw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_stb,
  input  mw_ins_e          dec_ins,
  input  logic [MW_AW-1:0] dec_addr,
  input  logic             pe,
  input  logic             commit,
  input  mw_ins_e          com_ins,
  input  logic [MW_AW-1:0] com_addr,
  output logic             grant,
  output logic             wen,
  output logic [MW_AW-1:0] bound,
  output logic             prot_clr,
  output logic             locked
);
  logic armed;

  always_comb begin
    case (dec_ins)
      I_READ, I_PRREAD, I_WDS: grant = 1'b1;
      I_WEN:   grant = pe;
      I_WRITE: grant = pe && wen && (prot_clr || mw_below(dec_addr, bound));
      I_WRALL: grant = pe && wen && prot_clr;
      I_PREN:  grant = pe && wen;
      I_PRCLR, I_PRDS: grant = pe && wen && armed && !locked;
      I_PRWR:  grant = pe && wen && armed && !locked && prot_clr;
      default: grant = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen      <= 1'b0;
      armed    <= 1'b0;
      prot_clr <= 1'b1;
      bound    <= '1;
      locked   <= 1'b0;
    end else begin
      if (dec_stb) begin
        armed <= (dec_ins == I_PREN) && grant;
        if (dec_ins == I_WEN && grant) wen <= 1'b1;
        if (dec_ins == I_WDS)          wen <= 1'b0;
      end
      if (commit) begin
        case (com_ins)
          I_PRCLR: begin prot_clr <= 1'b1; bound <= '1; end
          I_PRWR:  begin prot_clr <= 1'b0; bound <= com_addr; end
          I_PRDS:  locked <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int WORDS = MW_WORDS,
  parameter int DW    = MW_DW,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_one,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we_all || (we_one && waddr == AW'(g)))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 100,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)             left <= '0;
    else if (start)         left <= CW'(CYCLES);
    else if (left != '0)    left <= left - CW'(1);
  end

  assign busy = (left != '0);
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic pe,
  input  logic pre,
  output logic do_o,
  output logic do_oe
);
  localparam int CNTW = $clog2(MW_DW);

  mw_st_e             st;
  logic               sk_q, cs_q;
  logic [CNTW-1:0]    cnt;
  logic [MW_HDR-2:0]  cmd_sh;
  mw_ins_e            ins_q;
  logic [MW_AW-1:0]   addr_q, rd_addr;
  logic [MW_DW-1:0]   data_sh, rd_sh;
  logic [CNTW-1:0]    rd_cnt;
  logic               rd_bit, rd_prot, stat_show;

  // named internal events
  logic               sk_rise, cs_fall, dec_stb, prog_start, rd_start, st_idle;
  logic               we_one, we_all, busy, grant, wen, prot_clr, locked;
  logic [MW_HDR-1:0]  cmd_full;
  logic [MW_AW-1:0]   dec_addr, raddr, bound;
  mw_ins_e            dec_ins;
  logic [MW_DW-1:0]   rdata;

  assign sk_rise    = cs && sk && !sk_q;
  assign cs_fall    = cs_q && !cs;
  assign cmd_full   = {cmd_sh, di};
  assign dec_addr   = cmd_full[MW_AW-1:0];
  assign dec_ins    = mw_decode(cmd_full[MW_HDR-1 -: 2], dec_addr, pre);
  assign dec_stb    = (st == ST_CMD) && sk_rise && (cnt == CNTW'(MW_HDR - 1));
  assign rd_start   = dec_stb && (dec_ins == I_READ || dec_ins == I_PRREAD);
  assign prog_start = cs_fall && (st == ST_WAIT);
  assign we_one     = prog_start && (ins_q == I_WRITE);
  assign we_all     = prog_start && (ins_q == I_WRALL);
  assign raddr      = dec_stb ? dec_addr : mw_next(rd_addr);
  assign st_idle    = (st == ST_IDLE);

  mw_protect u_prot (
    .clk(clk), .rst_n(rst_n),
    .dec_stb(dec_stb), .dec_ins(dec_ins), .dec_addr(dec_addr), .pe(pe),
    .commit(prog_start), .com_ins(ins_q), .com_addr(addr_q),
    .grant(grant), .wen(wen), .bound(bound), .prot_clr(prot_clr), .locked(locked)
  );

  mw_array #(.WORDS(MW_WORDS), .DW(MW_DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we_one(we_one), .we_all(we_all), .waddr(addr_q), .wdata(data_sh),
    .raddr(raddr), .rdata(rdata)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sk_q      <= 1'b0;
      cs_q      <= 1'b0;
      cnt       <= '0;
      cmd_sh    <= '0;
      ins_q     <= I_NONE;
      addr_q    <= '0;
      data_sh   <= '0;
      rd_sh     <= '0;
      rd_addr   <= '0;
      rd_cnt    <= '0;
      rd_bit    <= 1'b0;
      rd_prot   <= 1'b0;
      stat_show <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (prog_start) stat_show <= 1'b1;
      if (!cs) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        rd_bit <= 1'b0;
      end else if (sk_rise) begin
        case (st)
          ST_IDLE: begin
            if (di && !busy) begin
              st        <= ST_CMD;
              cnt       <= '0;
              stat_show <= 1'b0;
            end
          end
          ST_CMD: begin
            cmd_sh <= cmd_full[MW_HDR-2:0];
            cnt    <= cnt + CNTW'(1);
            if (dec_stb) begin
              ins_q  <= dec_ins;
              addr_q <= dec_addr;
              cnt    <= '0;
              case (dec_ins)
                I_READ: begin
                  st <= ST_READ; rd_bit <= 1'b0; rd_sh <= rdata;
                  rd_addr <= dec_addr; rd_cnt <= '0; rd_prot <= 1'b0;
                end
                I_PRREAD: begin
                  st <= ST_READ; rd_bit <= 1'b0;
                  rd_sh <= {bound, {(MW_DW-MW_AW){1'b0}}};
                  rd_cnt <= '0; rd_prot <= 1'b1;
                end
                I_WRITE, I_WRALL:       st <= grant ? ST_DATA : ST_DEAD;
                I_PRCLR, I_PRWR, I_PRDS: st <= grant ? ST_WAIT : ST_DEAD;
                default:                st <= ST_DEAD;
              endcase
            end
          end
          ST_READ: begin
            rd_bit <= rd_sh[MW_DW-1];
            rd_cnt <= rd_cnt + CNTW'(1);
            if (rd_cnt == CNTW'(MW_DW - 1) && !rd_prot) begin
              rd_sh   <= rdata;
              rd_addr <= mw_next(rd_addr);
            end else begin
              rd_sh <= {rd_sh[MW_DW-2:0], 1'b0};
            end
          end
          ST_DATA: begin
            data_sh <= {data_sh[MW_DW-2:0], di};
            cnt     <= cnt + CNTW'(1);
            if (cnt == CNTW'(MW_DW - 1)) st <= ST_WAIT;
          end
          ST_WAIT: st <= ST_DEAD;
          default: ;
        endcase
      end
    end
  end

  assign do_oe = cs && ((st == ST_READ) || (st_idle && stat_show));
  assign do_o  = do_oe && ((st == ST_READ) ? rd_bit : !busy);
endmodule

// File: rtl/mw_serial_mem_chk.sv
module mw_serial_mem_chk
  import mw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             do_o,
  input logic             do_oe,
  input logic             busy,
  input logic             prog_start,
  input logic             st_idle,
  input logic             rd_start,
  input logic             we_one,
  input logic             we_all,
  input logic [MW_AW-1:0] waddr,
  input logic [MW_AW-1:0] bound,
  input logic             prot_clr,
  input logic             locked,
  input logic             wen
);
  p_tristate_cs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  p_prog_on_cs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (!cs && $past(cs)));

  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  p_busy_holds_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st_idle);

  p_dummy_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (!cs || (do_oe && !do_o)));

  p_write_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_one || we_all) |-> wen);

  p_write_below_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    we_one |-> (prot_clr || waddr < bound));

  p_wrall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_all |-> prot_clr);

  p_lock_freezes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(bound) && $stable(prot_clr) && locked));
endmodule

bind mw_serial_mem mw_serial_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .do_oe(do_oe),
  .busy(busy), .prog_start(prog_start), .st_idle(st_idle), .rd_start(rd_start),
  .we_one(we_one), .we_all(we_all), .waddr(addr_q), .bound(bound),
  .prot_clr(prot_clr), .locked(locked), .wen(wen)
);

// File: tb/tb_mw_serial_mem.sv
`timescale 1ns/1ps
module tb_mw_serial_mem;
  localparam int PROG = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b0, pre = 1'b0;
  wire  do_o, do_oe;
  int   total = 0, bad = 0;

  // behavioural reference state
  logic [15:0] m_mem [256];
  logic        m_wen, m_arm, m_clr, m_lock;
  logic [7:0]  m_pa;

  always #2.5 clk = ~clk;

  mw_serial_mem #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pe(pe), .pre(pre),
    .do_o(do_o), .do_oe(do_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: compared on every clock
  always @(negedge clk) if (rst_n && !cs) chk(!do_oe, "R8 oe with cs low", do_oe, 0);

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); sk = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk); sk = 1'b0; cs = 1'b0; pe = 1'b0; pre = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_cmd(input logic pr, input logic pv, input logic [1:0] op, input logic [7:0] a);
    @(negedge clk); cs = 1'b1; pre = pr; pe = pv; sk = 1'b0;
    sk_bit(1'b0);                        // R1: leading zero ignored
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = 7; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    while (do_oe && !do_o && n < 4*PROG) begin n++; @(negedge clk); end
    if (n > 0) chk(do_oe && do_o, "R6 ready shown", {do_oe, do_o}, 2'b11);
    end_frame();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic pv, output int n);
    send_cmd(1'b0, pv, 2'b01, a);
    pe = 1'b0;                           // R4: pe ignored after decode
    for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    end_frame();
    wait_ready(n);
    if (pv && m_wen && (m_clr || a < m_pa)) m_mem[a] = d;
    m_arm = 1'b0;
  endtask

  task automatic do_wrall(input logic [15:0] d);
    int n;
    send_cmd(1'b0, 1'b1, 2'b00, 8'h40);
    for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    end_frame();
    wait_ready(n);
    if (m_wen && m_clr) for (int i = 0; i < 256; i++) m_mem[i] = d;
    m_arm = 1'b0;
  endtask

  task automatic read_check(input logic [7:0] a, input int words, input string req);
    logic [15:0] w;
    send_cmd(1'b0, 1'b0, 2'b10, a);
    chk(do_oe && !do_o, {req, " dummy"}, {do_oe, do_o}, 2'b10);
    for (int k = 0; k < words; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin sk_bit(1'b0); w = {w[14:0], do_o}; end
      chk(w == m_mem[8'(a + k)], req, w, m_mem[8'(a + k)]);
    end
    end_frame();
    m_arm = 1'b0;
  endtask

  task automatic pr_read(input string req);
    logic [7:0] v;
    send_cmd(1'b1, 1'b0, 2'b10, 8'h00);
    chk(do_oe && !do_o, {req, " dummy"}, {do_oe, do_o}, 2'b10);
    v = '0;
    for (int b = 0; b < 8; b++) begin sk_bit(1'b0); v = {v[6:0], do_o}; end
    chk(v == m_pa, req, v, m_pa);
    sk_bit(1'b0);
    chk(!do_o, {req, " trailing zero"}, do_o, 0);
    end_frame();
    m_arm = 1'b0;
  endtask

  task automatic do_en(input logic on);
    send_cmd(1'b0, 1'b1, 2'b00, on ? 8'hC0 : 8'h00);
    chk(!do_oe, "R8 oe during enable frame", do_oe, 0);
    end_frame();
    m_wen = on; m_arm = 1'b0;
  endtask

  task automatic do_pren();
    send_cmd(1'b1, 1'b1, 2'b00, 8'hC0);
    end_frame();
    m_arm = m_wen;
  endtask

  // kind 0 clear, 1 set boundary, 2 lock
  task automatic do_pr(input int kind, input logic [7:0] a);
    int n;
    bit ok;
    case (kind)
      0: send_cmd(1'b1, 1'b1, 2'b11, 8'hFF);
      1: send_cmd(1'b1, 1'b1, 2'b01, a);
      default: send_cmd(1'b1, 1'b1, 2'b00, 8'h00);
    endcase
    end_frame();
    wait_ready(n);
    ok = m_wen && m_arm && !m_lock && (kind != 1 || m_clr);
    if (ok) case (kind)
      0: begin m_clr = 1'b1; m_pa = 8'hFF; end
      1: begin m_clr = 1'b0; m_pa = a; end
      default: m_lock = 1'b1;
    endcase
    m_arm = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_wen = 0; m_arm = 0; m_clr = 1; m_lock = 0; m_pa = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!do_oe && !do_o, "R8 reset outputs", {do_oe, do_o}, 0);

    read_check(8'h05, 1, "R2 read after reset");
    do_write(8'h10, 16'hA5C3, 1'b1, n);
    chk(n == 0, "R4 write refused before enable", n, 0);
    read_check(8'h10, 1, "R4 no enable");

    do_en(1'b1);
    do_write(8'h10, 16'hA5C3, 1'b1, n);
    chk(n >= PROG-8 && n <= PROG, "R6 busy length", n, PROG);
    read_check(8'h10, 1, "R5 word write");
    do_write(8'h17, 16'h1111, 1'b0, n);
    read_check(8'h17, 1, "R4 pe low at decode");

    do_write(8'h11, 16'h0F0F, 1'b1, n);
    read_check(8'h10, 2, "R3 streaming");
    do_write(8'hFF, 16'h1234, 1'b1, n);
    do_write(8'h00, 16'hBEEF, 1'b1, n);
    read_check(8'hFF, 2, "R3 wrap");

    // R5: extra clock before cs falls cancels the write
    send_cmd(1'b0, 1'b1, 2'b01, 8'h20);
    for (int i = 0; i < 17; i++) sk_bit(1'b1);
    end_frame();
    wait_ready(n);
    chk(n == 0, "R5 abort no busy", n, 0);
    read_check(8'h20, 1, "R5 abort");

    // R6: frame during busy is ignored, status stays busy
    send_cmd(1'b0, 1'b1, 2'b01, 8'h30);
    for (int i = 15; i >= 0; i--) sk_bit(i == 0);
    end_frame();
    m_mem[8'h30] = 16'h0001;
    @(negedge clk); cs = 1'b1;
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    for (int i = 7; i >= 0; i--) sk_bit(1'b1);
    for (int i = 0; i < 3; i++) begin
      sk_bit(1'b0);
      chk(do_oe && !do_o, "R6 busy ignores frame", {do_oe, do_o}, 2'b10);
    end
    end_frame();
    wait_ready(n);
    read_check(8'h30, 1, "R6 write during busy");

    do_wrall(16'h5A5A);
    read_check(8'h00, 1, "R7 write-all");
    read_check(8'h99, 1, "R7 write-all");

    pr_read("R9 boundary after reset");
    do_pr(1, 8'h80);
    pr_read("R10 set without arming");
    do_pren();
    do_pr(1, 8'h80);
    pr_read("R11 boundary set");
    read_check(8'h10, 1, "R9 pre low reads array");
    do_write(8'h80, 16'h1357, 1'b1, n);
    read_check(8'h80, 1, "R11 protected word");
    do_write(8'h7F, 16'h2468, 1'b1, n);
    read_check(8'h7F, 1, "R11 word below boundary");
    do_wrall(16'hFFFF);
    read_check(8'h00, 1, "R7 write-all refused");

    do_pren();
    do_pr(0, 8'h00);
    pr_read("R12 boundary cleared");
    do_write(8'h80, 16'h1357, 1'b1, n);
    read_check(8'h80, 1, "R12 unprotected");

    do_pren();
    do_en(1'b1);
    do_pr(1, 8'h40);
    pr_read("R10 chain broken");

    do_pren(); do_pr(1, 8'h40);
    do_pren(); do_pr(2, 8'h00);
    do_pren(); do_pr(0, 8'h00);
    pr_read("R13 clear after lock");
    do_write(8'h40, 16'hCAFE, 1'b1, n);
    read_check(8'h40, 1, "R13 locked region");

    // R14: partial frame discarded by cs low
    @(negedge clk); cs = 1'b1;
    sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1); sk_bit(1'b1);
    end_frame();
    read_check(8'h10, 1, "R14 resync after cs low");

    do_en(1'b0);
    do_write(8'h05, 16'h7777, 1'b1, n);
    read_check(8'h05, 1, "R4 after disable");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule